// File: doc/BRIEF.md
# Single-Wire Pixel Chain Serializer

This block drives a daisy chain of clockless RGB or RGBW pixels over one wire. A host pulses `start` with a pixel count and a colour-width select. The block then pulls bytes through a valid/ready stream and turns every bit into one fixed-length pulse. A short high time means a zero and a long high time means a one. When the frame is done, the block keeps the wire low for the reset interval that the pixels need before they show the new colours. At the end of that interval it pulses `done`.

All pulse lengths are cycle counts. They are worked out at elaboration from the `CLK_HZ` parameter. The bit period and the one-pulse length are rounded to the nearest cycle, and the zero-pulse length is truncated. If the clock is too slow to make a short enough zero pulse, elaboration stops. If the zero pulse is only marginally short enough, elaboration gives a warning.

The block holds one byte ahead of the byte on the wire. The host therefore has a whole byte time to present the next byte. If the host is late, the block does not stretch the bit stream. It ends the frame, starts the reset interval and raises a sticky underrun flag.

Top module: `pxl_chain_tx`

## Requirements
- R1: Each bit lasts PER cycles, with PER = round(CLK_HZ·1250 ns). A zero bit is high for trunc(CLK_HZ·350 ns) cycles and a one bit is high for round(CLK_HZ·900 ns) cycles. The wire is low for the rest of the bit. At 125 MHz these values are 156, 43 and 113 cycles.
- R2: Bits leave each byte most significant bit first. Bytes go out in the order they were accepted. Within a frame, consecutive rising edges are exactly PER cycles apart, with no gap between bytes or between pixels.
- R3: When `rgbw`=0 a frame carries 3 bytes per pixel, and when `rgbw`=1 it carries 4 bytes per pixel. The select is captured at `start`.
- R4: After the last bit of a frame, the wire stays low for at least 50 µs (RGB) or 80 µs (RGBW) before `done`. At 125 MHz that is 6250 or 10000 cycles. `done` comes no later than one bit period past that.
- R5: `busy` is high from the cycle after an accepted `start` until `done`. `done` is high for exactly one cycle, and `busy` falls on the same edge.
- R6: After reset, `line_out`, `busy`, `done`, `s_ready` and `underrun` are all low. `line_out` stays low whenever no frame is being sent.
- R7: If the next byte has not been accepted by the end of the current byte's last bit, the block stops sending, runs the reset interval and then gives `done`. `underrun` is then set and stays set until the next accepted `start`.
- R8: A `start` pulse while `busy` is high is ignored. The running frame keeps its byte count and its colour width.
- R9: A `start` with `frame_leds`=0 accepts no bytes and sends no pulse. It runs only the reset interval and then gives `done`.
- R10: The zero-bit high time is at most 450 ns at the default clock. Elaboration fails if this time exceeds 550 ns and warns if it exceeds 450 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to begin a frame |
| frame_leds | input | LED_W | Number of pixels in the frame |
| rgbw | input | 1 | 1: four bytes per pixel, 0: three |
| s_data | input | 8 | Stream byte |
| s_valid | input | 1 | Stream byte present |
| s_ready | output | 1 | Block accepts the stream byte this cycle |
| line_out | output | 1 | Serial pixel data line |
| busy | output | 1 | Frame or reset interval in progress |
| done | output | 1 | One-cycle pulse when the reset interval ends |
| underrun | output | 1 | Last frame ended early because a byte was late |

## Verification
The assertions assume that reset is synchronous and that the stream source never withdraws a byte it has offered. They also assume that `start` is a single-cycle pulse. The feeder in the bench keeps `s_valid` high until it sees `s_ready`, and only then moves on to the next byte. Its random idle gaps are at most 20 cycles, which is far shorter than one byte time. The one exception is the directed underrun case, where the feeder deliberately stops supplying bytes partway through a frame.

// File: rtl/pxl_pkg.sv
// Shared types and elaboration-time timing arithmetic for the pixel serializer.
// Assumes clock frequencies well below 10 GHz so 64-bit products never overflow.
package pxl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRIME,
        ST_SEND,
        ST_LATCH
    } pxl_state_e;

    // Short-pulse high time: truncated toward fewer cycles.
    function automatic int zero_cycles(input longint hz);
        return int'(((hz / 64'sd1000) * 64'sd350) / 64'sd1000000);
    endfunction

    // Long-pulse high time: rounded to nearest cycle.
    function automatic int one_cycles(input longint hz);
        return int'(((hz / 64'sd1000) * 64'sd900 + 64'sd500000) / 64'sd1000000);
    endfunction

    // Bit period: rounded to nearest cycle.
    function automatic int period_cycles(input longint hz);
        return int'(((hz / 64'sd1000) * 64'sd1250 + 64'sd500000) / 64'sd1000000);
    endfunction

    // Minimum low-hold in whole cycles for a given number of microseconds.
    function automatic int hold_cycles(input longint hz, input longint us);
        return int'((hz * us + 64'sd999999) / 64'sd1000000);
    endfunction

    // Duration of a cycle count in nanoseconds, truncated.
    function automatic longint cycles_ns(input longint hz, input int cyc);
        return (longint'(cyc) * 64'sd1000000000) / hz;
    endfunction

endpackage

// File: rtl/pxl_bit_timer.sv
// Bit-period timer: counts the cycles of one bit while run is high and drives
// the registered line high for the short or long part of the period.
// Assumes run is held for whole periods and bit_val is stable across a period.
module pxl_bit_timer #(
    parameter int PER_CYC  = 156,
    parameter int ZERO_CYC = 43,
    parameter int ONE_CYC  = 113
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic bit_val,
    output logic bit_last,
    output logic line
);
    localparam int CW = $clog2(PER_CYC);
    localparam logic [CW-1:0] LAST_CYC = CW'(PER_CYC - 1);

    logic [CW-1:0] cyc;
    logic [CW-1:0] hi_len;

    // Cycle position within the current bit, parked at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || cyc == LAST_CYC) begin
            cyc <= '0;
        end else begin
            cyc <= cyc + 1'b1;
        end
    end

    assign bit_last = run && (cyc == LAST_CYC);
    assign hi_len   = bit_val ? CW'(ONE_CYC) : CW'(ZERO_CYC);

    // Registered line level: high for the leading part of the period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line <= 1'b0;
        end else begin
            line <= run && (cyc < hi_len);
        end
    end

    // Line can only be high one cycle after the timer was running.
    assert_line_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> !line);

endmodule

// File: rtl/pxl_byte_feed.sv
// Stream intake with a one-byte holding register so the next byte is ready
// before the current one finishes. Counts the bytes still to be fetched.
// Assumes take is only raised while the holding register is full.
module pxl_byte_feed #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_count,
    input  logic             prime,
    input  logic             sending,
    input  logic             take,
    input  logic [7:0]       s_data,
    input  logic             s_valid,
    output logic             s_ready,
    output logic             accept,
    output logic             hold_full,
    output logic [7:0]       hold_data
);
    logic [CNT_W-1:0] fetch_left;

    assign s_ready = (fetch_left != '0) && (prime || (sending && !hold_full));
    assign accept  = s_valid && s_ready;

    // Byte budget and holding register; first byte bypasses the register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_left <= '0;
            hold_full  <= 1'b0;
            hold_data  <= '0;
        end else if (load) begin
            fetch_left <= load_count;
            hold_full  <= 1'b0;
        end else begin
            if (take) begin
                hold_full <= 1'b0;
            end
            if (accept && !prime) begin
                hold_data <= s_data;
                hold_full <= 1'b1;
            end
            if (accept) begin
                fetch_left <= fetch_left - 1'b1;
            end
        end
    end

    // The holding register only fills from an offered stream byte.
    assert_fill_from_stream_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_full) |-> $past(s_valid));

    // A byte is only consumed when one is held.
    assert_take_needs_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> hold_full);

endmodule

// File: rtl/pxl_chain_tx.sv
// Single-wire pixel chain serializer top: frame sequencing, byte shifting,
// underrun handling and the post-frame low hold. Timing derives from CLK_HZ.
// Assumes start is a one-cycle pulse and the stream source holds offered bytes.
module pxl_chain_tx #(
    parameter longint CLK_HZ = 125_000_000,
    parameter int     LED_W  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LED_W-1:0] frame_leds,
    input  logic             rgbw,
    input  logic [7:0]       s_data,
    input  logic             s_valid,
    output logic             s_ready,
    output logic             line_out,
    output logic             busy,
    output logic             done,
    output logic             underrun
);
    import pxl_pkg::*;

    localparam int     ZERO_CYC  = zero_cycles(CLK_HZ);
    localparam int     ONE_CYC   = one_cycles(CLK_HZ);
    localparam int     PER_CYC   = period_cycles(CLK_HZ);
    localparam int     HOLD3_CYC = hold_cycles(CLK_HZ, 64'sd50);
    localparam int     HOLD4_CYC = hold_cycles(CLK_HZ, 64'sd80);
    localparam longint ZERO_NS   = cycles_ns(CLK_HZ, ZERO_CYC);
    localparam int     CNT_W     = LED_W + 2;
    localparam int     LW        = $clog2(HOLD4_CYC + 1);

    // Elaboration guard on the short-pulse high time.
    generate
        if (ZERO_NS > 550) begin : g_zero_too_long
            $error("pxl_chain_tx: clock too slow, zero pulse exceeds 550 ns");
        end else if (ZERO_NS > 450) begin : g_zero_marginal
            $warning("pxl_chain_tx: zero pulse above 450 ns, timing marginal");
        end
    endgenerate

    pxl_state_e       state;
    logic             mode_q;
    logic [7:0]       sh;
    logic [2:0]       bit_idx;
    logic [CNT_W-1:0] send_left;
    logic [CNT_W-1:0] total;
    logic [LW-1:0]    lcnt;
    logic [LW-1:0]    lat_end;
    logic             done_q;
    logic             under_q;
    logic             start_ok;
    logic             bit_last;
    logic             accept;
    logic             hold_full;
    logic [7:0]       hold_data;
    logic             take;
    logic             last_byte;

    // Byte count for the requested frame: 3 or 4 per pixel.
    always_comb begin
        if (rgbw) begin
            total = {frame_leds, 2'b00};
        end else begin
            total = {1'b0, frame_leds, 1'b0} + {2'b00, frame_leds};
        end
    end

    assign start_ok  = start && (state == ST_IDLE);
    assign last_byte = (send_left == CNT_W'(1));
    assign take      = bit_last && (bit_idx == 3'd7) && !last_byte && hold_full;
    assign lat_end   = mode_q ? LW'(HOLD4_CYC - 1) : LW'(HOLD3_CYC - 1);

    pxl_bit_timer #(
        .PER_CYC (PER_CYC),
        .ZERO_CYC(ZERO_CYC),
        .ONE_CYC (ONE_CYC)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == ST_SEND),
        .bit_val (sh[7]),
        .bit_last(bit_last),
        .line    (line_out)
    );

    pxl_byte_feed #(
        .CNT_W(CNT_W)
    ) i_feed (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start_ok),
        .load_count(total),
        .prime     (state == ST_PRIME),
        .sending   (state == ST_SEND),
        .take      (take),
        .s_data    (s_data),
        .s_valid   (s_valid),
        .s_ready   (s_ready),
        .accept    (accept),
        .hold_full (hold_full),
        .hold_data (hold_data)
    );

    // Frame sequencer: wait for first byte, shift bits, then hold low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            mode_q    <= 1'b0;
            sh        <= '0;
            bit_idx   <= '0;
            send_left <= '0;
            lcnt      <= '0;
            done_q    <= 1'b0;
            under_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        mode_q    <= rgbw;
                        under_q   <= 1'b0;
                        send_left <= total;
                        lcnt      <= '0;
                        state     <= (total == '0) ? ST_LATCH : ST_PRIME;
                    end
                end
                ST_PRIME: begin
                    if (accept) begin
                        sh      <= s_data;
                        bit_idx <= '0;
                        state   <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (bit_last) begin
                        if (bit_idx == 3'd7) begin
                            send_left <= send_left - 1'b1;
                            lcnt      <= '0;
                            if (last_byte) begin
                                state <= ST_LATCH;
                            end else if (hold_full) begin
                                sh      <= hold_data;
                                bit_idx <= '0;
                            end else begin
                                under_q <= 1'b1;
                                state   <= ST_LATCH;
                            end
                        end else begin
                            sh      <= {sh[6:0], 1'b0};
                            bit_idx <= bit_idx + 3'd1;
                        end
                    end
                end
                ST_LATCH: begin
                    if (lcnt == lat_end) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        lcnt <= lcnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state != ST_IDLE);
    assign done     = done_q;
    assign underrun = under_q;

    // done never overlaps a running frame.
    assert_done_not_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // busy only drops together with the done pulse.
    assert_busy_until_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // Line is low throughout the hold interval.
    assert_hold_line_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LATCH && $past(state == ST_LATCH)) |-> !line_out);

    // A start during a frame leaves the captured width untouched.
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (mode_q == $past(mode_q)));

endmodule

// File: tb/test_pxl_chain_tx.sv
`timescale 1ns/1ps
module test_pxl_chain_tx;
    localparam longint HZ = 125_000_000;

    function automatic int b_zero();  return int'((HZ / 1000 * 350) / 1000000); endfunction
    function automatic int b_one();   return int'((HZ / 1000 * 900 + 500000) / 1000000); endfunction
    function automatic int b_per();   return int'((HZ / 1000 * 1250 + 500000) / 1000000); endfunction
    function automatic int b_hold(input int us); return int'((HZ * us + 999999) / 1000000); endfunction

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [9:0] frame_leds = '0;
    logic       rgbw = 1'b0;
    logic [7:0] s_data = '0;
    logic       s_valid = 1'b0;
    logic       s_ready, line_out, busy, done, underrun;

    int n_checks = 0;
    int n_err = 0;
    int cyc_n = 0;

    logic [7:0] pat [0:15];
    logic [7:0] dec [0:255];
    int         dec_n = 0;

    logic       line_d = 1'b0;
    int         last_rise = 0;
    int         last_fall = 0;
    bit         have_rise = 0;
    logic [7:0] acc = '0;
    int         nb = 0;

    pxl_chain_tx #(.CLK_HZ(HZ), .LED_W(10)) i_pxl_chain_tx (
        .clk(clk), .rst_n(rst_n), .start(start), .frame_leds(frame_leds),
        .rgbw(rgbw), .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
        .line_out(line_out), .busy(busy), .done(done), .underrun(underrun)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc_n <= cyc_n + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        if (cyc_n > 195000) begin
            chk(0, "WDOG", "cycles", cyc_n, 195000);
            summary();
            $finish;
        end
    end

    // Line monitor: pulse widths (R1, R10), period (R2), bit decode.
    always @(negedge clk) begin
        int  w;
        bit  bv;
        if (rst_n) begin
            if (line_out && !line_d) begin
                if (have_rise && (cyc_n - last_rise) < 2 * b_per())
                    chk((cyc_n - last_rise) == b_per(), "R2", "bit period",
                        cyc_n - last_rise, b_per());
                last_rise = cyc_n;
                have_rise = 1;
            end
            if (!line_out && line_d) begin
                w = cyc_n - last_rise;
                last_fall = cyc_n;
                if (w == b_zero()) begin
                    bv = 0;
                    chk(longint'(w) * 8 <= 450, "R10", "zero high ns", longint'(w) * 8, 450);
                end else if (w == b_one()) begin
                    bv = 1;
                end else begin
                    chk(0, "R1", "high width", w, b_zero());
                    bv = (w > (b_zero() + b_one()) / 2);
                end
                acc = {acc[6:0], bv};
                nb++;
                if (nb == 8) begin
                    if (dec_n < 256) dec[dec_n] = acc;
                    dec_n++;
                    nb = 0;
                end
            end
        end
        line_d = line_out;
    end

    task automatic feed(input int supply);
        for (int i = 0; i < supply; i++) begin
            @(negedge clk);
            s_valid = 1'b1;
            s_data  = pat[i];
            while (!s_ready) @(negedge clk);
            @(negedge clk);
            s_valid = 1'b0;
            repeat ($urandom_range(0, 20)) @(negedge clk);
        end
    endtask

    task automatic run_frame(input int leds, input bit mode, input int supply,
                             input bit poke, input bit exp_under);
        int  nbytes = leds * (mode ? 4 : 3);
        int  base = dec_n;
        int  t0;
        int  t_done = 0;
        int  exp_n;
        bit  busy_ok = 1;
        bit  poked = 0;
        int  hold = b_hold(mode ? 80 : 50);
        @(negedge clk);
        start = 1'b1;
        frame_leds = 10'(leds);
        rgbw = mode;
        t0 = cyc_n;
        fork
            feed(supply);
            begin
                @(negedge clk);
                start = 1'b0;
                while (!done && (cyc_n - t0) < 60000) begin
                    if (!busy) busy_ok = 0;
                    if (poke && !poked && (cyc_n - t0) >= 300) begin
                        start = 1'b1;
                        frame_leds = 10'd7;
                        rgbw = ~mode;
                        poked = 1;
                    end else begin
                        start = 1'b0;
                    end
                    @(negedge clk);
                end
                start = 1'b0;
                t_done = cyc_n;
            end
        join
        chk(done == 1'b1, "R5", "done seen", done, 1);
        chk(busy_ok, "R5", "busy held until done", busy_ok, 1);
        chk(busy == 1'b0, "R5", "busy low at done", busy, 0);
        chk(underrun == exp_under, "R7", "underrun flag", underrun, exp_under);
        exp_n = exp_under ? supply : nbytes;
        chk((dec_n - base) == exp_n, poke ? "R8" : "R3", "bytes on line", dec_n - base, exp_n);
        for (int i = 0; i < exp_n && i < 16; i++)
            chk(dec[base + i] == pat[i], "R2", "byte value", dec[base + i], pat[i]);
        if (nbytes == 0) begin
            chk((t_done - t0) >= hold && (t_done - t0) <= hold + 4, "R9",
                "empty frame hold", t_done - t0, hold);
        end else begin
            chk((t_done - last_fall) >= hold && (t_done - last_fall) <= hold + b_per(),
                "R4", "low hold before done", t_done - last_fall, hold);
        end
        @(negedge clk);
        chk(done == 1'b0, "R5", "done one cycle", done, 0);
    endtask

    initial begin
        void'($urandom(32'd5150));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(line_out == 0, "R6", "reset line", line_out, 0);
        chk(busy == 0, "R6", "reset busy", busy, 0);
        chk(done == 0, "R6", "reset done", done, 0);
        chk(s_ready == 0, "R6", "reset s_ready", s_ready, 0);
        chk(underrun == 0, "R6", "reset underrun", underrun, 0);

        // R1 R3: three-byte pixel, all-zero, all-one and mixed bytes.
        pat[0] = 8'h00; pat[1] = 8'hFF; pat[2] = 8'hA5;
        run_frame(1, 0, 3, 0, 0);

        // R6: line stays low while idle.
        begin
            bit low_ok = 1;
            repeat (200) begin
                @(negedge clk);
                if (line_out) low_ok = 0;
            end
            chk(low_ok, "R6", "idle line low", low_ok, 1);
        end

        // R3 R4: four-byte pixel, MSB and LSB set alone.
        pat[0] = 8'h80; pat[1] = 8'h01; pat[2] = 8'h5A; pat[3] = 8'hC3;
        run_frame(1, 1, 4, 0, 0);

        // R9: empty frames in both widths.
        run_frame(0, 0, 0, 0, 0);
        run_frame(0, 1, 0, 0, 0);

        // R7: only two of six bytes supplied.
        pat[0] = 8'h3C; pat[1] = 8'hE7;
        run_frame(2, 0, 2, 0, 1);

        // R8: start during a frame is ignored; also clears underrun (R7).
        pat[0] = 8'h11; pat[1] = 8'h22; pat[2] = 8'h99;
        run_frame(1, 0, 3, 1, 0);

        // Random frames.
        for (int f = 0; f < 3; f++) begin
            int  leds = 1 + int'($urandom % 2);
            bit  mode = 1'($urandom % 2);
            for (int i = 0; i < 16; i++) pat[i] = 8'($urandom);
            run_frame(leds, mode, leds * (mode ? 4 : 3), 0, 0);
        end

        summary();
        $finish;
    end

endmodule